// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block supervises software through a single write port carrying an enable bit and a key of a few bits. After reset the watchdog is idle. Writing the enable bit set arms it and records the key. While armed, software keeps it alive only by writing the bitwise complement of the key it holds. With enable set, such a write restarts the supervision interval and the complement becomes the new key. With enable clear, such a write disarms the watchdog. A write whose key is not the complement only replaces the stored key. It does not touch the timing.

If the first supervision interval runs out, the block emits a one-cycle non-maskable interrupt request and enters a shorter grace interval. A valid restart during the grace interval returns it to a fresh first interval. If the grace interval also runs out, the block emits a one-cycle chip reset request and returns to the idle state. Both interval lengths are parameters in clock cycles. The defaults correspond to 100 ms and 3.3 ms at a 1 MHz count rate.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, wd_running, nmi_req and chip_rst_req are all low.
- R2: wr_data bit KEY_W is the enable bit and bits KEY_W-1:0 are the key. While idle, a write with enable clear has no effect: wd_running stays low and no pulse follows.
- R3: While idle, a write with enable set arms the watchdog and stores the written key. wd_running is high from the cycle after the write.
- R4: While armed, a write with enable clear and a key equal to the bitwise NOT of the stored key disarms the watchdog. wd_running drops in the next cycle, and no pulse follows.
- R5: While armed, a write with enable set and the inverted key restarts the first interval and stores the written value as the new key.
- R6: While armed, a write with any other key replaces the stored key, whatever the enable bit. It neither restarts nor stops the watchdog.
- R7: nmi_req is a one-cycle pulse. It is high in the cycle that follows the STAGE1_CYCLES-th clock edge after the arming or restart write edge, provided no valid service write comes in between.
- R8: chip_rst_req is a one-cycle pulse STAGE2_CYCLES edges after the nmi_req edge. In that same cycle wd_running is low.
- R9: A valid restart during the grace interval cancels the pending chip reset and starts a new first interval.
- R10: A valid service write on the very edge where an interval would expire takes priority, and that interval's pulse is not produced.
- R11: wd_running is high exactly while the watchdog is armed, and that includes the grace interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | KEY_W+1 | Enable bit (MSB) and key |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| chip_rst_req | output | 1 | One-cycle chip reset request |
| wd_running | output | 1 | Watchdog armed status |

## Verification
A service write and an interval expiry can land on the same clock edge. Both the first-interval expiry (interrupt) and the grace expiry (reset) have this collision. The bench provokes each case by timing the write so that it is sampled on exactly the STAGE1_CYCLES-th edge or the (STAGE1_CYCLES+STAGE2_CYCLES)-th edge after arming. It then judges the result cycle by cycle: the colliding pulse must never appear, and the next interrupt must come a full first interval after the colliding write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // Supervision phase of the watchdog
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_FIRST  = 2'd1,
      PH_GRACE  = 2'd2
   } wd_phase_e;

   // Decoded meaning of a register write
   typedef enum logic [1:0] {
      CMD_NONE    = 2'd0,
      CMD_ARM     = 2'd1,
      CMD_RESTART = 2'd2,
      CMD_DISARM  = 2'd3
   } wd_cmd_e;

endpackage

// File: rtl/wdog_key_unit.sv
module wdog_key_unit
   import wdog_pkg::*;
#(
   parameter int KEY_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [KEY_W:0]   wr_data,
   input  logic             armed_i,
   output wd_cmd_e          cmd_o
);

   localparam int EN_BIT = KEY_W;

   logic [KEY_W-1:0] key_q;
   logic [KEY_W-1:0] wr_key;
   logic             wr_enable;
   logic             key_match;

   assign wr_key    = wr_data[KEY_W-1:0];
   assign wr_enable = wr_data[EN_BIT];

   // Per-bit complement compare
   logic [KEY_W-1:0] bit_ok;
   for (genvar b = 0; b < KEY_W; b++) begin : g_cmp
      assign bit_ok[b] = (wr_key[b] != key_q[b]);
   end
   assign key_match = &bit_ok;

   always_comb begin
      cmd_o = CMD_NONE;
      if (wr_en) begin
         if (!armed_i) begin
            if (wr_enable) cmd_o = CMD_ARM;
         end else if (key_match) begin
            cmd_o = wr_enable ? CMD_RESTART : CMD_DISARM;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
      end else if (wr_en && (armed_i || wr_enable)) begin
         key_q <= wr_key;
      end
   end

   AST_IDLE_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_i |-> (cmd_o != CMD_RESTART && cmd_o != CMD_DISARM)); // R2
   AST_KEY_REPLACED: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_i && wr_en) |=> (key_q == $past(wr_key))); // R6

endmodule

// File: rtl/wdog_phase_timer.sv
module wdog_phase_timer
   import wdog_pkg::*;
#(
   parameter int STAGE1_CYCLES = 100000,
   parameter int STAGE2_CYCLES = 3300
) (
   input  logic    clk,
   input  logic    rst_n,
   input  wd_cmd_e cmd_i,
   output logic    armed_o,
   output logic    nmi_o,
   output logic    rst_req_o
);

   localparam int LONGEST = (STAGE1_CYCLES > STAGE2_CYCLES) ? STAGE1_CYCLES : STAGE2_CYCLES;
   localparam int CNT_W   = $clog2(LONGEST + 1);
   localparam logic [CNT_W-1:0] LAST1 = CNT_W'(STAGE1_CYCLES - 1);
   localparam logic [CNT_W-1:0] LAST2 = CNT_W'(STAGE2_CYCLES - 1);

   wd_phase_e        phase_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         nmi_o     <= 1'b0;
         rst_req_o <= 1'b0;
      end else begin
         nmi_o     <= 1'b0;
         rst_req_o <= 1'b0;
         unique case (cmd_i)
            CMD_ARM, CMD_RESTART: begin
               phase_q <= PH_FIRST;
               cnt_q   <= '0;
            end
            CMD_DISARM: begin
               phase_q <= PH_IDLE;
               cnt_q   <= '0;
            end
            default: begin
               case (phase_q)
                  PH_FIRST: begin
                     if (cnt_q == LAST1) begin
                        phase_q <= PH_GRACE;
                        cnt_q   <= '0;
                        nmi_o   <= 1'b1;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
                  PH_GRACE: begin
                     if (cnt_q == LAST2) begin
                        phase_q   <= PH_IDLE;
                        cnt_q     <= '0;
                        rst_req_o <= 1'b1;
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
                  default: cnt_q <= '0;
               endcase
            end
         endcase
      end
   end

   assign armed_o = (phase_q != PH_IDLE);

   AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |=> !nmi_o); // R7
   AST_NMI_ENTERS_GRACE: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |-> (phase_q == PH_GRACE)); // R7
   AST_RST_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> !armed_o); // R8
   AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o); // R8
   AST_RESTART_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_RESTART) |=> (phase_q == PH_FIRST && cnt_q == '0 && !nmi_o && !rst_req_o)); // R10
   AST_DISARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_DISARM) |=> (!armed_o && !nmi_o && !rst_req_o)); // R4

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import wdog_pkg::*;
#(
   parameter int KEY_W         = 3,
   parameter int STAGE1_CYCLES = 100000,
   parameter int STAGE2_CYCLES = 3300
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [KEY_W:0]   wr_data,
   output logic             nmi_req,
   output logic             chip_rst_req,
   output logic             wd_running
);

   if (KEY_W < 1) begin : g_bad_key
      $error("keyed_watchdog: KEY_W must be at least 1");
   end
   if (STAGE1_CYCLES < 1 || STAGE2_CYCLES < 1) begin : g_bad_len
      $error("keyed_watchdog: interval lengths must be at least 1 cycle");
   end

   wd_cmd_e cmd;
   logic    armed;

   wdog_key_unit #(
      .KEY_W (KEY_W)
   ) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .armed_i (armed),
      .cmd_o   (cmd)
   );

   wdog_phase_timer #(
      .STAGE1_CYCLES (STAGE1_CYCLES),
      .STAGE2_CYCLES (STAGE2_CYCLES)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_i     (cmd),
      .armed_o   (armed),
      .nmi_o     (nmi_req),
      .rst_req_o (chip_rst_req)
   );

   assign wd_running = armed;

   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(nmi_req && chip_rst_req)); // R8
   AST_IDLE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!wd_running && wr_en && !wr_data[KEY_W]) |=> (!wd_running && !nmi_req && !chip_rst_req)); // R2
   AST_ARM_SETS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      (!wd_running && wr_en && wr_data[KEY_W]) |=> wd_running); // R3

endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

   localparam int KW = 3;
   localparam int S1 = 20;
   localparam int S2 = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [KW:0]   wr_data = '0;
   logic          nmi_req, chip_rst_req, wd_running;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   keyed_watchdog #(.KEY_W(KW), .STAGE1_CYCLES(S1), .STAGE2_CYCLES(S2)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .nmi_req(nmi_req), .chip_rst_req(chip_rst_req), .wd_running(wd_running));

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Called and returns at a negedge; the write is sampled on the next posedge
   task automatic wr(input logic en, input logic [KW-1:0] k);
      wr_en   = 1'b1;
      wr_data = {en, k};
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Watch n edges; expect nmi after edge nmi_at, reset after edge rst_at (0 = never)
   task automatic watch(input string req, input int n, input int nmi_at, input int rst_at);
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         check(req, $sformatf("nmi_req after edge %0d", k), nmi_req, (k == nmi_at));
         check(req, $sformatf("chip_rst_req after edge %0d", k), chip_rst_req, (k == rst_at));
      end
   endtask

   task automatic t_reset();
      check("R1", "wd_running after reset", wd_running, 0);
      check("R1", "nmi_req after reset", nmi_req, 0);
      check("R1", "chip_rst_req after reset", chip_rst_req, 0);
   endtask

   task automatic t_idle_ignore();
      wr(1'b0, 3'd3);
      check("R2", "running after enable-clear write while idle", wd_running, 0);
      watch("R2", S1 + S2 + 2, 0, 0);
      check("R2", "still idle", wd_running, 0);
   endtask

   task automatic t_full_timeout();
      wr(1'b1, 3'd2);
      check("R3", "running after arm", wd_running, 1);
      watch("R7", S1 + S2 + 1, S1, S1 + S2);
      check("R8", "idle after chip reset", wd_running, 0);
   endtask

   task automatic t_restart();
      wr(1'b1, 3'd3);
      idle(9);
      wr(1'b1, 3'd4);          // ~3 = 4
      check("R11", "running after restart", wd_running, 1);
      watch("R5", S1 + S2 + 1, S1, S1 + S2);
   endtask

   task automatic t_wrong_key();
      wr(1'b1, 3'd2);          // edge 1 relative to arm = E0
      idle(5);                 // E1..E5
      wr(1'b1, 3'd1);          // E6: not ~2, key becomes 1, no restart
      check("R6", "running after wrong-key write", wd_running, 1);
      watch("R6", S1 - 6, S1 - 6, 0);  // nmi still on original schedule
      check("R11", "running during grace", wd_running, 1);
      wr(1'b1, 3'd6);          // ~1 = 6 proves key 1 was stored; cancels reset
      watch("R9", S1 + S2 + 1, S1, S1 + S2);
   endtask

   task automatic t_stop();
      wr(1'b1, 3'd5);
      idle(2);
      wr(1'b0, 3'd5);          // not ~5: key change only
      check("R6", "enable-clear wrong key keeps running", wd_running, 1);
      wr(1'b0, 3'd2);          // ~5 = 2: disarm
      check("R4", "running after disarm", wd_running, 0);
      watch("R4", S1 + S2 + 2, 0, 0);
   endtask

   task automatic t_collide_nmi();
      wr(1'b1, 3'd0);
      idle(S1 - 1);
      wr(1'b1, 3'd7);          // sampled on edge S1
      check("R10", "nmi_req at colliding edge", nmi_req, 0);
      watch("R10", S1 + S2 + 1, S1, S1 + S2);
   endtask

   task automatic t_collide_rst();
      wr(1'b1, 3'd6);
      idle(S1 + S2 - 1);
      wr(1'b1, 3'd1);          // ~6 = 1, sampled on edge S1+S2
      check("R10", "chip_rst_req at colliding edge", chip_rst_req, 0);
      check("R10", "running after colliding restart", wd_running, 1);
      watch("R10", S1 + S2 + 1, S1, S1 + S2);
      check("R11", "idle at end", wd_running, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_idle_ignore();
      t_full_timeout();
      t_restart();
      t_wrong_key();
      t_stop();
      t_collide_nmi();
      t_collide_rst();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: bench hung, actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule